// File: doc/BRIEF.md
# Integer Execution Unit with Set-on-Compare

This block is the integer datapath of a small load/store processor. Each cycle it takes a first source word and a second operand, plus a five-bit operation code. The second operand is either a second register word or an immediate, chosen by a select line. It produces a 32-bit result and a flag that is high when that result is zero. The operations are wrapping add and subtract, the three bitwise operations, three kinds of shift, and twelve set-on-compare operations. Each set-on-compare operation writes the word 1 when its relation holds and the word 0 when it does not.

Alongside the result, a branch-condition output tests the first source word. It tests either for zero or for nonzero, as the branch in flight requires. A fetch unit can use this output directly to decide whether a conditional branch is taken. An operation code that is not defined forces the result to zero and raises an illegal-operation flag.

A parameter places one register stage on the result and on every flag. With the stage in place, the outputs follow the inputs by one clock, and a synchronous active-high reset clears them. With the stage removed, the outputs are purely combinational.

Top module: `int_alu`

## Requirements
- R1: Code 0 returns src_a plus the second operand, and code 1 returns src_a minus the second operand. Both wrap modulo 2^32 and no overflow is reported.
- R2: Code 2 returns the bitwise AND of src_a and the second operand, code 3 returns the bitwise OR, and code 4 returns the bitwise XOR.
- R3: Code 5 shifts src_a left logically, code 6 shifts it right logically, and code 7 shifts it right arithmetically. The shift amount is the low 5 bits of the second operand, and its upper bits are ignored.
- R4: Every compare returns 1 in bit 0 when its relation holds and 0 when it does not. Bits 31:1 of a compare result are always zero.
- R5: Codes 8 to 13 are signed compares in two's-complement order: 8 is equal, 9 not equal, 10 less than, 11 greater than, 12 less or equal, 13 greater or equal.
- R6: Codes 16 to 21 are the same six relations, in the same order, using unsigned order.
- R7: When sel_imm is 1 the second operand is imm_val, and src_b has no effect. When sel_imm is 0 the second operand is src_b.
- R8: res_zero is 1 exactly when result is all zeros.
- R9: Codes 14, 15 and 22 to 31 are undefined. For these codes result is zero and illegal is 1. For every defined code illegal is 0.
- R10: br_taken is 1 when br_on_nz is 0 and src_a is zero, or when br_on_nz is 1 and src_a is nonzero. It does not depend on op_sel.
- R11: With REG_OUT=1 (the default), all outputs appear one clock after their inputs. While rst is high, result, res_zero, br_taken and illegal are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 5 | Operation code |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| imm_val | input | 32 | Immediate word |
| sel_imm | input | 1 | 1 selects imm_val as the second operand |
| br_on_nz | input | 1 | Branch test: 0 tests src_a for zero, 1 tests it for nonzero |
| result | output | 32 | Operation result |
| res_zero | output | 1 | High when result is zero |
| br_taken | output | 1 | Outcome of the branch test |
| illegal | output | 1 | High for an undefined operation code |

## Verification
The most revealing cases are operands with the top bit set. Comparing -1 with 1 gives opposite answers under signed and unsigned order, so a design that swapped the two orders, or shared one comparator for both, would return the wrong bit. An arithmetic right shift of a negative word must fill with ones, where a logical fill would clear the top bits. A shift amount with bits above bit 4 set shows whether the design truncates the amount or treats the shift as too large and returns zero. Adding 1 to all ones must wrap to zero, and a design that carried into extra width would show a wrong result. The bench also drives undefined codes, drives the immediate path with a conflicting src_b, and tries both polarities of the branch test on zero and nonzero words.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_SUB  = 5'd1,
    OP_AND  = 5'd2,
    OP_OR   = 5'd3,
    OP_XOR  = 5'd4,
    OP_SLL  = 5'd5,
    OP_SRL  = 5'd6,
    OP_SRA  = 5'd7,
    OP_SEQ  = 5'd8,
    OP_SNE  = 5'd9,
    OP_SLT  = 5'd10,
    OP_SGT  = 5'd11,
    OP_SLE  = 5'd12,
    OP_SGE  = 5'd13,
    OP_SEQU = 5'd16,
    OP_SNEU = 5'd17,
    OP_SLTU = 5'd18,
    OP_SGTU = 5'd19,
    OP_SLEU = 5'd20,
    OP_SGEU = 5'd21
  } alu_op_e;

  // relation index taken from the low three bits of a compare code
  typedef enum logic [2:0] {
    REL_EQ = 3'd0,
    REL_NE = 3'd1,
    REL_LT = 3'd2,
    REL_GT = 3'd3,
    REL_LE = 3'd4,
    REL_GE = 3'd5
  } rel_e;

  function automatic logic is_cmp(input logic [4:0] op);
    return ((op >= 5'd8) && (op <= 5'd13)) || ((op >= 5'd16) && (op <= 5'd21));
  endfunction
endpackage

// File: rtl/alu_addcmp.sv
module alu_addcmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [2:0]        rel,
  input  logic              unsgn,
  output logic [DATA_W-1:0] sum,
  output logic [DATA_W-1:0] diff,
  output logic              rel_true
);
  import alu_pkg::*;

  logic is_eq, is_lt;

  assign sum  = opnd_a + opnd_b;
  assign diff = opnd_a - opnd_b;

  assign is_eq = (opnd_a == opnd_b);
  assign is_lt = unsgn ? (opnd_a < opnd_b) : ($signed(opnd_a) < $signed(opnd_b));

  always_comb begin
    unique case (rel)
      REL_EQ:  rel_true = is_eq;
      REL_NE:  rel_true = !is_eq;
      REL_LT:  rel_true = is_lt;
      REL_GT:  rel_true = !is_lt && !is_eq;
      REL_LE:  rel_true = is_lt || is_eq;
      REL_GE:  rel_true = !is_lt;
      default: rel_true = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_bitshift.sv
module alu_bitshift #(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] or_o,
  output logic [DATA_W-1:0] xor_o,
  output logic [DATA_W-1:0] sll_o,
  output logic [DATA_W-1:0] srl_o,
  output logic [DATA_W-1:0] sra_o
);
  logic [SH_W-1:0] amt;

  assign amt   = opnd_b[SH_W-1:0];
  assign and_o = opnd_a & opnd_b;
  assign or_o  = opnd_a | opnd_b;
  assign xor_o = opnd_a ^ opnd_b;
  assign sll_o = opnd_a << amt;
  assign srl_o = opnd_a >> amt;
  assign sra_o = DATA_W'($signed(opnd_a) >>> amt);
endmodule

// File: rtl/alu_brcond.sv
module alu_brcond #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word,
  input  logic              want_nz,
  output logic              taken
);
  logic nz;

  assign nz    = |word;
  assign taken = want_nz ? nz : !nz;
endmodule

// File: rtl/int_alu.sv
module int_alu #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        op_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] imm_val,
  input  logic              sel_imm,
  input  logic              br_on_nz,
  output logic [DATA_W-1:0] result,
  output logic              res_zero,
  output logic              br_taken,
  output logic              illegal
);
  import alu_pkg::*;

  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] sum, diff, and_w, or_w, xor_w, sll_w, srl_w, sra_w;
  logic              rel_true, taken_c;
  logic [DATA_W-1:0] res_c;
  logic              bad_c;

  assign opnd_b = sel_imm ? imm_val : src_b;

  alu_addcmp #(.DATA_W(DATA_W)) u_addcmp (
    .opnd_a   (src_a),
    .opnd_b   (opnd_b),
    .rel      (op_sel[2:0]),
    .unsgn    (op_sel[4]),
    .sum      (sum),
    .diff     (diff),
    .rel_true (rel_true)
  );

  alu_bitshift #(.DATA_W(DATA_W)) u_bitshift (
    .opnd_a (src_a),
    .opnd_b (opnd_b),
    .and_o  (and_w),
    .or_o   (or_w),
    .xor_o  (xor_w),
    .sll_o  (sll_w),
    .srl_o  (srl_w),
    .sra_o  (sra_w)
  );

  alu_brcond #(.DATA_W(DATA_W)) u_brcond (
    .word    (src_a),
    .want_nz (br_on_nz),
    .taken   (taken_c)
  );

  always_comb begin
    bad_c = 1'b0;
    res_c = '0;
    if (is_cmp(op_sel)) begin
      res_c = DATA_W'(rel_true);
    end else begin
      case (op_sel)
        OP_ADD:  res_c = sum;
        OP_SUB:  res_c = diff;
        OP_AND:  res_c = and_w;
        OP_OR:   res_c = or_w;
        OP_XOR:  res_c = xor_w;
        OP_SLL:  res_c = sll_w;
        OP_SRL:  res_c = srl_w;
        OP_SRA:  res_c = sra_w;
        default: bad_c = 1'b1;
      endcase
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          result   <= '0;
          res_zero <= 1'b0;
          br_taken <= 1'b0;
          illegal  <= 1'b0;
        end else begin
          result   <= res_c;
          res_zero <= (res_c == '0);
          br_taken <= taken_c;
          illegal  <= bad_c;
        end
      end
    end else begin : g_comb
      assign result   = res_c;
      assign res_zero = (res_c == '0);
      assign br_taken = taken_c;
      assign illegal  = bad_c;
    end
  endgenerate
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [4:0]        op_sel,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic [DATA_W-1:0] imm_val,
  input logic              sel_imm,
  input logic              br_on_nz,
  input logic [DATA_W-1:0] result,
  input logic              res_zero,
  input logic              br_taken,
  input logic              illegal
);
  logic [4:0]        p_op;
  logic [DATA_W-1:0] p_a, p_b;
  logic              p_nz, p_ok;
  logic [DATA_W-1:0] p_sum;
  logic              p_cmp;

  // inputs aligned with the outputs they produce
  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk) begin
        p_op <= op_sel;
        p_a  <= src_a;
        p_b  <= sel_imm ? imm_val : src_b;
        p_nz <= br_on_nz;
        p_ok <= !rst;
      end
    end else begin : g_now
      assign p_op = op_sel;
      assign p_a  = src_a;
      assign p_b  = sel_imm ? imm_val : src_b;
      assign p_nz = br_on_nz;
      assign p_ok = !rst;
    end
  endgenerate

  assign p_sum = p_a + p_b;
  assign p_cmp = ((p_op >= 5'd8) && (p_op <= 5'd13)) || ((p_op >= 5'd16) && (p_op <= 5'd21));

  a_r1_add_wrap: assert property (@(posedge clk) disable iff (rst)
    (p_ok && p_op == 5'd0) |-> result == p_sum);

  a_r4_cmp_upper_clear: assert property (@(posedge clk) disable iff (rst)
    (p_ok && p_cmp) |-> result[DATA_W-1:1] == '0);

  a_r8_zero_flag: assert property (@(posedge clk) disable iff (rst)
    p_ok |-> res_zero == (result == '0));

  a_r9_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    (p_ok && illegal) |-> result == '0);

  a_r10_branch: assert property (@(posedge clk) disable iff (rst)
    p_ok |-> br_taken == (p_nz ? (p_a != '0) : (p_a == '0)));
endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/int_alu_bench.sv
module int_alu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_sel = '0;
  logic [31:0] src_a = '0, src_b = '0, imm_val = '0;
  logic        sel_imm = 1'b0, br_on_nz = 1'b0;
  logic [31:0] result;
  logic        res_zero, br_taken, illegal;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  int_alu u_int_alu (.*);

  // {op, a, b, expected}
  localparam int NV = 25;
  localparam logic [100:0] VEC [NV] = '{
    {5'd0,  32'h0000_0007, 32'h0000_0005, 32'h0000_000C}, // R1
    {5'd0,  32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0001}, // R1 wrap
    {5'd0,  32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000}, // R1 wrap to zero
    {5'd1,  32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE}, // R1 borrow
    {5'd2,  32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000}, // R2
    {5'd3,  32'hF0F0_F0F0, 32'h0F0F_0000, 32'hFFFF_F0F0}, // R2
    {5'd4,  32'hAAAA_5555, 32'hFFFF_0000, 32'h5555_5555}, // R2
    {5'd5,  32'h0000_0001, 32'h0000_001F, 32'h8000_0000}, // R3
    {5'd5,  32'h0000_0001, 32'h0000_0023, 32'h0000_0008}, // R3 low 5 bits
    {5'd6,  32'h8000_0000, 32'h0000_0004, 32'h0800_0000}, // R3
    {5'd7,  32'h8000_0000, 32'h0000_0004, 32'hF800_0000}, // R3 sign fill
    {5'd7,  32'h7FFF_FFF0, 32'h0000_0004, 32'h07FF_FFFF}, // R3
    {5'd8,  32'h0000_0005, 32'h0000_0005, 32'h0000_0001}, // R5
    {5'd9,  32'h0000_0005, 32'h0000_0005, 32'h0000_0000}, // R5
    {5'd10, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001}, // R5 -1<1
    {5'd11, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001}, // R5
    {5'd12, 32'h0000_0004, 32'h0000_0004, 32'h0000_0001}, // R5
    {5'd13, 32'h0000_0003, 32'h0000_0004, 32'h0000_0000}, // R5
    {5'd16, 32'h0000_0009, 32'h0000_0009, 32'h0000_0001}, // R6
    {5'd17, 32'h0000_0009, 32'h0000_0008, 32'h0000_0001}, // R6
    {5'd18, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000}, // R6
    {5'd19, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000}, // R6
    {5'd20, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0000}, // R6
    {5'd21, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001}, // R6
    {5'd1,  32'h1234_5678, 32'h1234_5678, 32'h0000_0000}  // R1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on a falling edge, sample on the next falling edge (one register)
  task automatic apply(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] im, input logic si, input logic nz);
    @(negedge clk);
    op_sel = op; src_a = a; src_b = b; imm_val = im; sel_imm = si; br_on_nz = nz;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset result", result, 32'h0);
    check("R11 reset flags", {29'h0, res_zero, br_taken, illegal}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][100:96], VEC[i][95:64], VEC[i][63:32], 32'hDEAD_BEEF, 1'b0, 1'b0);
      check($sformatf("R1-6 vector %0d (R4 width) op %0d", i, VEC[i][100:96]), result, VEC[i][31:0]);
      check($sformatf("R8 vector %0d", i), {31'h0, res_zero}, {31'h0, VEC[i][31:0] == 32'h0});
      check($sformatf("R9 vector %0d legal", i), {31'h0, illegal}, 32'h0);
    end

    // R7: immediate replaces src_b
    apply(5'd0, 32'd10, 32'd999, 32'd3, 1'b1, 1'b0);
    check("R7 imm add", result, 32'd13);
    apply(5'd10, 32'd5, 32'd1, 32'd9, 1'b1, 1'b0);
    check("R7 imm compare", result, 32'd1);

    // R9: undefined codes
    apply(5'd14, 32'hFFFF_FFFF, 32'h1, 32'h0, 1'b0, 1'b0);
    check("R9 code 14 result", result, 32'h0);
    check("R9 code 14 flag", {31'h0, illegal}, 32'h1);
    apply(5'd31, 32'h1234, 32'h1, 32'h0, 1'b0, 1'b0);
    check("R9 code 31 result", result, 32'h0);
    check("R9 code 31 flag", {31'h0, illegal}, 32'h1);
    apply(5'd22, 32'h1234, 32'h1, 32'h0, 1'b0, 1'b0);
    check("R9 code 22 flag", {31'h0, illegal}, 32'h1);

    // R10: branch test on both polarities
    apply(5'd2, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0);
    check("R10 zero test on zero", {31'h0, br_taken}, 32'h1);
    apply(5'd2, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1);
    check("R10 nz test on zero", {31'h0, br_taken}, 32'h0);
    apply(5'd14, 32'h8000_0000, 32'h0, 32'h0, 1'b0, 1'b1);
    check("R10 nz test on nonzero", {31'h0, br_taken}, 32'h1);
    apply(5'd0, 32'h8000_0000, 32'h0, 32'h0, 1'b0, 1'b0);
    check("R10 zero test on nonzero", {31'h0, br_taken}, 32'h0);

    // R11: one-cycle latency, and reset clears outputs
    @(negedge clk);
    op_sel = 5'd0; src_a = 32'd100; src_b = 32'd1; sel_imm = 1'b0;
    #1;
    check("R11 output not yet updated", result, 32'h8000_0000);
    @(negedge clk);
    check("R11 output after one clock", result, 32'd101);
    rst = 1'b1;
    @(negedge clk);
    check("R11 reset clears result", result, 32'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule